// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Maskable Interrupts

This block is an asynchronous serial port on a small word-addressed register bus. Software sets a bit period in system clocks through a divisor register. It then hands bytes to a one-character transmit holding register and collects received bytes from a one-character receive register. The line format is fixed: one start bit, eight data bits sent least significant bit first, no parity and one stop bit. Between the holding register and the line sits a shift register, so one byte can wait while another is on the wire.

A status word reports the transmitter, the receiver, the latched error flags and a synchronised copy of the clear-to-send input. A control word has an interrupt enable at the same bit position as each interrupting status flag. The control word also holds the break request and the request-to-send level. The single interrupt output is the OR of every enabled, active flag.

Bus accesses complete in one cycle and are never stalled. The transmit holding register is the only point of back-pressure: the tx-ready flag is its ready signal. A write made while it is low is a protocol violation, which is recorded and then dropped. The receive side has no back-pressure at all. A byte that completes while the previous one is still unread replaces it, and the loss is recorded.

Top module: `mmio_uart`

## Requirements
- R1: After reset the status word (word 2) reads 0x0060, the control word (word 3) reads 0, the divisor (word 4) reads DIV_INIT, `txd` is high, and `irq` and `rts_out` are low.
- R2: A byte written to word 1 goes out as a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts exactly divisor clocks, and the frame starts in the clock after the byte leaves the holding register.
- R3: The receiver samples each bit near its middle. On a complete frame it stores the byte and sets status bit 7 (rx ready). A read of word 0 returns the byte in bits 7:0 and clears bit 7.
- R4: Status bit 6 (tx ready) is high while the holding register is empty. Status bit 5 (tx idle) is high only when the holding register is empty and the shifter has finished its stop bit.
- R5: A write to word 1 while bit 6 is low sets status bit 4 (tx overrun), and the byte is never transmitted.
- R6: A frame that completes while bit 7 is set, with no read of word 0 in that cycle, overwrites the byte and sets status bit 3 (rx overrun). A read of word 0 in the completing cycle returns the old byte, leaves bit 7 set with the new byte, and sets no overrun.
- R7: A frame whose stop bit is 0 sets status bit 1 (framing error). If its eight data bits are also all 0, it sets status bit 2 (break) as well. The byte is still delivered.
- R8: Status bit 8 is the OR of bits 1 to 4. A write of any value to word 2 clears bits 1, 2, 3, 4, 8 and 10.
- R9: `irq` is high exactly when status[k] and control[k] are both 1 for some k in {0..8, 10, 12}. Control bits 9 and 11 never raise `irq`.
- R10: While control bit 9 is set, `txd` is held low.
- R11: `rts_out` follows control bit 11.
- R12: Status bit 11 is `cts_in` after a two-flop synchroniser. Status bit 10 latches on any change of that synchronised level and stays set until a write to word 2.
- R13: Status bits 0 and 12 always read 0, and word addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; qualifies the side effect of reading word 0 |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for `bus_addr`, valid in the same cycle |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| cts_in | input | 1 | Clear-to-send level from the far end |
| rts_out | output | 1 | Request-to-send level, from control bit 11 |
| irq | output | 1 | Interrupt request, level sensitive |

## Verification
The case that matters is a software read of the receive register that falls in the same clock as the completion of the next incoming frame. There the consume and the overwrite compete for the ready flag and the overrun flag. The bench provokes it by preloading one byte and starting a second frame. It then sweeps the read across a window of clock offsets that straddles the frame's end, so that exactly one offset lands on the completing cycle. Each offset is judged by which byte the read returned. If the old byte came back, no overrun may be set and the new byte must be waiting. If the new byte came back, the overrun must be set and the receiver must be empty.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // register bus geometry
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] REG_RXD  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_TXD  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] REG_DIV  = 3'd4;

  // status / control word layout (software decodes these positions)
  localparam int ST_W      = 13;
  localparam int ST_PAR    = 0;
  localparam int ST_FRM    = 1;
  localparam int ST_BRK    = 2;
  localparam int ST_ROVR   = 3;
  localparam int ST_TOVR   = 4;
  localparam int ST_TIDLE  = 5;
  localparam int ST_TRDY   = 6;
  localparam int ST_RRDY   = 7;
  localparam int ST_EXC    = 8;
  localparam int CT_SBRK   = 9;
  localparam int ST_CTSCHG = 10;
  localparam int ST_CTS    = 11;
  localparam int CT_RTS    = 11;
  localparam int ST_EOP    = 12;

  // control bits that act as interrupt enables
  localparam logic [ST_W-1:0] IRQ_EN_MASK = 13'h15FF;

  localparam int DATA_BITS = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     div,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 in_ready,
  output logic                 line,
  output logic                 idle
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  logic [DATA_BITS-1:0]  hold_q;
  logic                  full_q;
  logic                  busy_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic [DIV_W-1:0]      cnt_q;
  logic [DIV_W-1:0]      div_last;

  assign div_last = (div == '0) ? '0 : div - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (in_valid && !full_q) begin
        hold_q <= in_data;
        full_q <= 1'b1;
      end
      if (!busy_q) begin
        if (full_q) begin
          sh_q   <= {1'b1, hold_q, 1'b0};
          busy_q <= 1'b1;
          full_q <= 1'b0;
          cnt_q  <= '0;
          idx_q  <= '0;
        end
      end else if (cnt_q >= div_last) begin
        cnt_q <= '0;
        sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
        if (idx_q == IDX_W'(FRAME_BITS - 1)) busy_q <= 1'b0;
        else                                 idx_q  <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign in_ready = !full_q;
  assign line     = busy_q ? sh_q[0] : 1'b1;
  assign idle     = !full_q && !busy_q;

  // R2
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !line);

  // R5
  hold_no_clobber_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(hold_q));
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     div,
  input  logic                 line,
  output logic                 out_valid,
  output logic [DATA_BITS-1:0] out_data,
  output logic                 out_frm,
  output logic                 out_brk
);
  localparam int IDX_W = $clog2(DATA_BITS);

  rx_state_e            st_q;
  logic [DIV_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] sh_q;
  logic [DIV_W-1:0]     div_last;
  logic [DIV_W-1:0]     half;
  logic [DIV_W-1:0]     half_lim;

  assign div_last = (div == '0) ? '0 : div - 1'b1;
  assign half     = div >> 1;
  assign half_lim = (half == '0) ? '0 : half - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= RX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      sh_q      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_frm   <= 1'b0;
      out_brk   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
        end
        RX_START: begin
          if (cnt_q >= half_lim) begin
            cnt_q <= '0;
            idx_q <= '0;
            st_q  <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q >= div_last) begin
            cnt_q <= '0;
            sh_q  <= {line, sh_q[DATA_BITS-1:1]};
            if (idx_q == IDX_W'(DATA_BITS - 1)) st_q  <= RX_STOP;
            else                                idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q >= div_last) begin
            cnt_q     <= '0;
            out_valid <= 1'b1;
            out_data  <= sh_q;
            out_frm   <= !line;
            out_brk   <= !line && (sh_q == '0);
            st_q      <= line ? RX_IDLE : RX_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (line) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7
  brk_has_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_brk) |-> out_frm);
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import sp_pkg::*;
#(
  parameter int               BUS_W    = 16,
  parameter int               DIV_W    = 16,
  parameter logic [DIV_W-1:0] DIV_INIT = 16'd434,
  parameter int               SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              rxd,
  output logic              txd,
  input  logic              cts_in,
  output logic              rts_out,
  output logic              irq
);
  // decoded accesses
  logic tx_wr, st_wr, ctrl_wr, div_wr, rx_rd;
  assign tx_wr   = bus_wr && (bus_addr == REG_TXD);
  assign st_wr   = bus_wr && (bus_addr == REG_STAT);
  assign ctrl_wr = bus_wr && (bus_addr == REG_CTRL);
  assign div_wr  = bus_wr && (bus_addr == REG_DIV);
  assign rx_rd   = bus_rd && (bus_addr == REG_RXD);

  // configuration
  logic [ST_W-1:0]  ctrl_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DIV_INIT;
    end else begin
      if (ctrl_wr) ctrl_q <= bus_wdata[ST_W-1:0];
      if (div_wr)  div_q  <= bus_wdata[DIV_W-1:0];
    end
  end

  // line synchronisers
  logic rxd_s, cts_s, cts_d;

  sp_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

  sp_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_in), .q(cts_s));

  // transmitter
  logic tx_ready, tx_line, tx_idle, tx_ovr;
  assign tx_ovr = tx_wr && !tx_ready;

  sp_tx #(.DIV_W(DIV_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .div      (div_q),
    .in_valid (tx_wr),
    .in_data  (bus_wdata[DATA_BITS-1:0]),
    .in_ready (tx_ready),
    .line     (tx_line),
    .idle     (tx_idle)
  );

  // receiver
  logic                 rx_valid, rx_frm, rx_brk;
  logic [DATA_BITS-1:0] rx_byte;

  sp_rx #(.DIV_W(DIV_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .div       (div_q),
    .line      (rxd_s),
    .out_valid (rx_valid),
    .out_data  (rx_byte),
    .out_frm   (rx_frm),
    .out_brk   (rx_brk)
  );

  // latched receive data and flags; a new event wins over a clearing write
  logic [DATA_BITS-1:0] rx_data_q;
  logic rrdy_q, frm_q, brk_q, roe_q, toe_q, dcts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_q <= '0;
      rrdy_q    <= 1'b0;
      frm_q     <= 1'b0;
      brk_q     <= 1'b0;
      roe_q     <= 1'b0;
      toe_q     <= 1'b0;
      dcts_q    <= 1'b0;
      cts_d     <= 1'b0;
    end else begin
      cts_d <= cts_s;

      if (rx_valid)   rx_data_q <= rx_byte;

      if (rx_valid)   rrdy_q <= 1'b1;
      else if (rx_rd) rrdy_q <= 1'b0;

      if (rx_valid && rx_frm)         frm_q <= 1'b1;
      else if (st_wr)                 frm_q <= 1'b0;

      if (rx_valid && rx_brk)         brk_q <= 1'b1;
      else if (st_wr)                 brk_q <= 1'b0;

      if (rx_valid && rrdy_q && !rx_rd) roe_q <= 1'b1;
      else if (st_wr)                   roe_q <= 1'b0;

      if (tx_ovr)                     toe_q <= 1'b1;
      else if (st_wr)                 toe_q <= 1'b0;

      if (cts_s != cts_d)             dcts_q <= 1'b1;
      else if (st_wr)                 dcts_q <= 1'b0;
    end
  end

  // status word
  logic [ST_W-1:0] stat;

  always_comb begin
    stat            = '0;
    stat[ST_PAR]    = 1'b0;
    stat[ST_FRM]    = frm_q;
    stat[ST_BRK]    = brk_q;
    stat[ST_ROVR]   = roe_q;
    stat[ST_TOVR]   = toe_q;
    stat[ST_TIDLE]  = tx_idle;
    stat[ST_TRDY]   = tx_ready;
    stat[ST_RRDY]   = rrdy_q;
    stat[ST_EXC]    = frm_q | brk_q | roe_q | toe_q;
    stat[ST_CTSCHG] = dcts_q;
    stat[ST_CTS]    = cts_s;
    stat[ST_EOP]    = 1'b0;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_RXD:  bus_rdata[DATA_BITS-1:0] = rx_data_q;
      REG_STAT: bus_rdata[ST_W-1:0]      = stat;
      REG_CTRL: bus_rdata[ST_W-1:0]      = ctrl_q;
      REG_DIV:  bus_rdata[DIV_W-1:0]     = div_q;
      default:  bus_rdata                = '0;
    endcase
  end

  assign irq     = |(stat & ctrl_q & IRQ_EN_MASK);
  assign rts_out = ctrl_q[CT_RTS];
  assign txd     = ctrl_q[CT_SBRK] ? 1'b0 : tx_line;

  // R6
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rrdy_q && !rx_rd) |=> (roe_q && rrdy_q));

  // R5
  tx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && !tx_ready) |=> toe_q);

  // R8
  exc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !rx_valid) |=> !stat[ST_EXC]);

  // R12
  cts_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_s != cts_d) |=> dcts_q);
endmodule

// File: tb/mmio_uart_bench.sv
module mmio_uart_bench;
  localparam int BUS_W = 16;
  localparam int DIV_W = 16;
  localparam logic [15:0] DIV_INIT = 16'd434;
  localparam logic [12:0] EN_MASK  = 13'h15FF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [2:0]  addr;
  logic        wr, rd;
  logic [15:0] wdata, rdata;
  logic        txd, rxd, bench_rx, loop, cts, rts, irq;
  logic [15:0] rv;

  assign rxd = loop ? txd : bench_rx;

  int nchk  = 0;
  int nfail = 0;
  int cur_div = 16'd434;

  mmio_uart #(.BUS_W(BUS_W), .DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_mmio_uart (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .rxd(rxd), .txd(txd),
    .cts_in(cts), .rts_out(rts), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic bw(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    addr = a; rd = 1'b1;
    @(negedge clk);
    v = rdata;
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic drive_bit(input logic b);
    #1 bench_rx = b;
    repeat (cur_div) @(posedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopb);
    @(posedge clk);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stopb);
    #1 bench_rx = 1'b1;
  endtask

  task automatic wait_rrdy(output bit got);
    logic [15:0] s;
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      br(3'd2, s);
      if (s[7]) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic ctrl_sweep(input string tag);
    logic [15:0] s;
    br(3'd2, s);
    for (int v = 0; v < 8192; v++) begin
      logic [12:0] cv;
      cv = 13'(v);
      bw(3'd3, {3'b000, cv});
      @(negedge clk);
      // R9
      chk(irq == (|(s[12:0] & cv & EN_MASK)), {"R9 irq ", tag}, irq, |(s[12:0] & cv & EN_MASK));
      // R11
      chk(rts == cv[11], "R11 rts follows ctrl", rts, cv[11]);
      // R10
      chk(txd == !cv[9], "R10 break holds line", txd, !cv[9]);
    end
    bw(3'd3, 16'h0000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] s, v;
    bit got;
    int seen_old, seen_new;
    logic [7:0] tbytes [4];

    rst_n = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    bench_rx = 1'b1; loop = 1'b0; cts = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    br(3'd2, s); chk(s == 16'h0060, "R1 status", s, 16'h0060);
    br(3'd3, s); chk(s == 16'h0000, "R1 control", s, 0);
    br(3'd4, s); chk(s == DIV_INIT, "R1 divisor", s, DIV_INIT);
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(rts == 1'b0, "R1 rts", rts, 0);

    // R13 unused addresses
    for (int a = 5; a < 8; a++) begin
      br(3'(a), s);
      chk(s == 16'h0000, "R13 empty address", s, 0);
    end

    // R2 bit timing, divisor 5
    cur_div = 5;
    bw(3'd4, 16'd5);
    tbytes[0] = 8'hA5; tbytes[1] = 8'h3C; tbytes[2] = 8'h81; tbytes[3] = 8'hFE;
    for (int t = 0; t < 4; t++) begin
      int pos;
      bw(3'd1, {8'h00, tbytes[t]});
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!txd) break;
      end
      pos = 0;
      for (int j = 0; j < 10; j++) begin
        logic e;
        int target;
        target = j * cur_div + cur_div / 2;
        while (pos < target) begin
          @(negedge clk);
          pos++;
        end
        e = (j == 0) ? 1'b0 : (j == 9) ? 1'b1 : tbytes[t][j-1];
        chk(txd == e, "R2 frame bit", txd, e);
      end
      repeat (3 * cur_div) @(posedge clk);
    end
    begin
      int run;
      bw(3'd1, 16'h0000);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!txd) break;
      end
      run = 0;
      while (!txd && run < 200) begin
        run++;
        @(negedge clk);
      end
      chk(run == 9 * cur_div, "R2 low run of zero byte", run, 9 * cur_div);
      repeat (3 * cur_div) @(posedge clk);
      br(3'd2, s);
      chk(s[5] == 1'b1, "R4 tx idle after frame", s[5], 1);
    end

    // R3 loopback sweep over every byte value, divisor 4
    cur_div = 4;
    bw(3'd4, 16'd4);
    loop = 1'b1;
    for (int b = 0; b < 256; b++) begin
      bw(3'd1, 16'(b));
      wait_rrdy(got);
      br(3'd0, v);
      chk(got && v[7:0] == 8'(b), "R3 loopback byte", v[7:0], b);
    end
    br(3'd2, s);
    chk(s[8:1] == 8'b0011_0000, "R3 clean status after sweep", s[8:1], 8'b0011_0000);

    // R4 / R5 holding register and tx overrun
    bw(3'd1, 16'h0011);
    br(3'd2, s);
    chk(s[6] == 1'b1 && s[5] == 1'b0, "R4 ready while shifting", s[6:5], 2'b10);
    bw(3'd1, 16'h0022);
    br(3'd2, s);
    chk(s[6] == 1'b0, "R4 holding full", s[6], 0);
    bw(3'd1, 16'h0033);
    br(3'd2, s);
    chk(s[4] == 1'b1 && s[8] == 1'b1, "R5 tx overrun and R8 exception", s[8:4], 5'b10001);
    bw(3'd3, 16'h0010);
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq on tx overrun", irq, 1);
    wait_rrdy(got); br(3'd0, v);
    chk(got && v[7:0] == 8'h11, "R5 first byte", v[7:0], 8'h11);
    wait_rrdy(got); br(3'd0, v);
    chk(got && v[7:0] == 8'h22, "R5 second byte", v[7:0], 8'h22);
    repeat (120) @(posedge clk);
    br(3'd2, s);
    chk(s[7] == 1'b0, "R5 discarded byte never sent", s[7], 0);
    chk(s[6:4] == 3'b111, "R4 idle and ready, overrun held", s[6:4], 3'b111);
    bw(3'd2, 16'h0000);
    br(3'd2, s);
    chk(s[4] == 1'b0 && s[8] == 1'b0, "R8 status write clears", {s[8], s[4]}, 0);
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq drops after clear", irq, 0);
    bw(3'd3, 16'h0000);
    loop = 1'b0;

    // R6 rx overrun
    send_rx(8'h55, 1'b1);
    send_rx(8'h66, 1'b1);
    repeat (10) @(posedge clk);
    br(3'd2, s);
    chk(s[3] == 1'b1 && s[7] == 1'b1 && s[8] == 1'b1, "R6 rx overrun", {s[8], s[7], s[3]}, 3'b111);
    br(3'd0, v);
    chk(v[7:0] == 8'h66, "R6 newest byte kept", v[7:0], 8'h66);
    bw(3'd2, 16'h0000);

    // R6 read colliding with frame completion
    seen_old = 0; seen_new = 0;
    for (int k = 30; k <= 52; k++) begin
      logic [7:0] ab, bb;
      logic [15:0] v2;
      ab = 8'h10 + 8'(k);
      bb = 8'hC0 - 8'(k);
      send_rx(ab, 1'b1);
      repeat (8) @(posedge clk);
      bw(3'd2, 16'h0000);
      fork
        send_rx(bb, 1'b1);
        begin
          repeat (k) @(posedge clk);
          br(3'd0, rv);
        end
      join
      repeat (3 * cur_div) @(posedge clk);
      br(3'd2, s);
      if (rv[7:0] == ab) begin
        seen_old++;
        chk(s[3] == 1'b0, "R6 same-cycle read no overrun", s[3], 0);
        chk(s[7] == 1'b1, "R6 new byte waiting", s[7], 1);
        br(3'd0, v2);
        chk(v2[7:0] == bb, "R6 new byte value", v2[7:0], bb);
      end else if (rv[7:0] == bb) begin
        seen_new++;
        chk(s[3] == 1'b1, "R6 late read overrun", s[3], 1);
        chk(s[7] == 1'b0, "R6 late read empties", s[7], 0);
      end else begin
        chk(1'b0, "R6 collision read value", rv[7:0], ab);
      end
    end
    chk(seen_old > 0 && seen_new > 0, "R6 sweep straddles completion", {seen_old[15:0], seen_new[15:0]}, 0);
    bw(3'd2, 16'h0000);

    // R7 framing error and break
    send_rx(8'h5A, 1'b0);
    repeat (10) @(posedge clk);
    br(3'd2, s);
    chk(s[1] == 1'b1 && s[2] == 1'b0 && s[8] == 1'b1 && s[7] == 1'b1, "R7 framing error", s[8:0], 9'h182);
    br(3'd0, v);
    chk(v[7:0] == 8'h5A, "R7 byte delivered", v[7:0], 8'h5A);
    bw(3'd2, 16'h0000);
    send_rx(8'h00, 1'b0);
    repeat (10) @(posedge clk);
    br(3'd2, s);
    chk(s[1] == 1'b1 && s[2] == 1'b1, "R7 break", s[2:1], 2'b11);
    br(3'd0, v);
    chk(v[7:0] == 8'h00, "R7 break byte", v[7:0], 0);

    // R12 clear-to-send tracking
    #1 cts = 1'b1;
    repeat (5) @(posedge clk);
    br(3'd2, s);
    chk(s[11] == 1'b1 && s[10] == 1'b1, "R12 cts rise", s[11:10], 2'b11);
    bw(3'd2, 16'h0000);
    br(3'd2, s);
    chk(s[11] == 1'b1 && s[10] == 1'b0, "R12 change cleared, level kept", s[11:10], 2'b10);
    #1 cts = 1'b0;
    repeat (5) @(posedge clk);
    br(3'd2, s);
    chk(s[11] == 1'b0 && s[10] == 1'b1, "R12 cts fall", s[11:10], 2'b01);

    // R9 R10 R11 exhaustive control sweep, state with cts change only
    ctrl_sweep("cts-change state");

    // state with errors and a pending byte
    send_rx(8'h00, 1'b0);
    repeat (10) @(posedge clk);
    br(3'd2, s);
    chk(s[0] == 1'b0 && s[12] == 1'b0, "R13 fixed zero bits", {s[12], s[0]}, 0);
    ctrl_sweep("error state");

    bw(3'd2, 16'h0000);
    br(3'd0, v);
    br(3'd2, s);
    chk(s == 16'h0060, "R8 back to quiet status", s, 16'h0060);

    finish_run();
  end
endmodule